// File: doc/BRIEF.md
# Lock-Guarded Configuration Register Bank

This block is a small memory-mapped register bank on a simple synchronous bus. The bus has a write strobe, a read strobe, a byte address, a 32-bit write word and a registered 32-bit read word. The bank holds two kinds of register. General-purpose registers accept writes at any time. Guarded registers accept a write only when an arming key was written to a dedicated key register on the bus write just before.

Arming covers exactly one guarded write. That write uses up the arming even when the data it carries matches what is already stored. Any other bus write in between disarms the bank. A read-only configuration word reports a hardware revision code in its top nibble. Software reaches the guarded registers with a two-write sequence: first the key, then the target. The sequence must be repeated for every guarded update.

Top module: `cfg_lock_bank`

## Requirements
- R1: After synchronous reset, every writable register reads 0 and the bank is disarmed, so the key register reads 0.
- R2: General-purpose registers at offsets 0x00 and 0x04 store any written 32-bit word regardless of the arming state.
- R3: A write to a guarded register at offset 0x20, 0x24 or 0x80 while disarmed is dropped, and the register keeps its value.
- R4: Writing a word whose low byte is 0xAA to the key register at offset 0xC0 arms the bank. The next bus write, if it targets a guarded register, stores its data.
- R5: A guarded write disarms the bank whether or not the stored value changes. A second guarded write without a new key is dropped.
- R6: Writing a word whose low byte is not 0xAA to the key register disarms the bank.
- R7: Any write to an offset other than the key register disarms the bank, including general-purpose, read-only and unmapped offsets.
- R8: Reading the key register returns 1 in bit 0 while armed and 0 when disarmed. All other bits read 0.
- R9: The configuration word at offset 0x9C reads the revision code in bits 31:28. Bit 0 is 1 when that code is 6 or 7 and 0 for any other code. All other bits read 0, and writes to it have no effect.
- R10: Read data appears on the clock edge that samples the read strobe and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | DATA_W | Write word |
| rd_data | output | DATA_W | Registered read word |

## Verification
A write takes effect on the edge that samples it. The arming state therefore reflects the key write from the next cycle onward. Read data is due one edge after the read strobe is sampled. The bench drives each strobe for one cycle starting on a falling edge, and samples read data on the following falling edge. Every result is observed half a cycle after the edge that produced it. Arming state is checked only through key-register reads, which do not disturb it.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int N_PROT = 3;
  localparam logic [7:0] KEY_OFS   = 8'hC0;
  localparam logic [7:0] CFG_OFS   = 8'h9C;
  localparam logic [7:0] PLAIN_BASE = 8'h00;
  localparam logic [7:0] ARM_KEY   = 8'hAA;

  function automatic logic [7:0] prot_ofs(input int idx);
    case (idx)
      0:       return 8'h20;
      1:       return 8'h24;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic rev_known(input logic [3:0] code);
    return (code == 4'd6) || (code == 4'd7);
  endfunction
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_PLAIN = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit_key,
  output logic               hit_cfg,
  output logic [N_PROT-1:0]  hit_prot,
  output logic [N_PLAIN-1:0] hit_plain
);
  assign hit_key = (addr == ADDR_W'(KEY_OFS));
  assign hit_cfg = (addr == ADDR_W'(CFG_OFS));

  for (genvar g = 0; g < N_PROT; g++) begin : g_prot
    assign hit_prot[g] = (addr == ADDR_W'(prot_ofs(g)));
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    assign hit_plain[g] = (addr == ADDR_W'(PLAIN_BASE + 8'(4 * g)));
  end
endmodule

// File: rtl/cfg_lock_arm.sv
module cfg_lock_arm
  import cfg_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       hit_key,
  input  logic [7:0] wbyte,
  output logic       armed
);
  // Every bus write re-evaluates the arming: only the key byte to the key
  // register arms, anything else (including the guarded write) disarms.
  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (wr_en)
      armed <= hit_key && (wbyte == ARM_KEY);
  end
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfg_lock_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          N_PLAIN  = 2,
  parameter logic [3:0]  REV_CODE = 4'd7
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic                           armed,
  input  logic                           hit_key,
  input  logic                           hit_cfg,
  input  logic [N_PROT-1:0]              hit_prot,
  input  logic [N_PLAIN-1:0]             hit_plain,
  input  logic [DATA_W-1:0]              wdata,
  output logic [N_PROT-1:0][DATA_W-1:0]  prot_q,
  output logic [DATA_W-1:0]              rd_data
);
  localparam logic [DATA_W-1:0] CFG_WORD =
    {REV_CODE, {(DATA_W-5){1'b0}}, rev_known(REV_CODE)};

  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [DATA_W-1:0]              rd_nxt;

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst)
        plain_q[g] <= '0;
      else if (wr_en && hit_plain[g])
        plain_q[g] <= wdata;
    end
  end

  for (genvar g = 0; g < N_PROT; g++) begin : g_prot
    always_ff @(posedge clk) begin
      if (rst)
        prot_q[g] <= '0;
      else if (wr_en && hit_prot[g] && armed)
        prot_q[g] <= wdata;
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < N_PLAIN; i++)
      if (hit_plain[i]) rd_nxt = rd_nxt | plain_q[i];
    for (int i = 0; i < N_PROT; i++)
      if (hit_prot[i]) rd_nxt = rd_nxt | prot_q[i];
    if (hit_key) rd_nxt = rd_nxt | DATA_W'(armed);
    if (hit_cfg) rd_nxt = rd_nxt | CFG_WORD;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_nxt;
  end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter int         N_PLAIN  = 2,
  parameter logic [3:0] REV_CODE = 4'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic                          hit_key;
  logic                          hit_cfg;
  logic [N_PROT-1:0]             hit_prot;
  logic [N_PLAIN-1:0]            hit_plain;
  logic                          armed;
  logic [N_PROT-1:0][DATA_W-1:0] prot_q;

  cfg_lock_decode #(.ADDR_W(ADDR_W), .N_PLAIN(N_PLAIN)) u_dec (
    .addr(addr), .hit_key(hit_key), .hit_cfg(hit_cfg),
    .hit_prot(hit_prot), .hit_plain(hit_plain)
  );

  cfg_lock_arm u_arm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .hit_key(hit_key),
    .wbyte(wdata[7:0]), .armed(armed)
  );

  cfg_lock_regs #(.DATA_W(DATA_W), .N_PLAIN(N_PLAIN), .REV_CODE(REV_CODE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .armed(armed),
    .hit_key(hit_key), .hit_cfg(hit_cfg), .hit_prot(hit_prot),
    .hit_plain(hit_plain), .wdata(wdata), .prot_q(prot_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk
  import cfg_lock_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter logic [3:0] REV_CODE = 4'd7
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic                          rd_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [DATA_W-1:0]             wdata,
  input logic [DATA_W-1:0]             rd_data,
  input logic                          armed,
  input logic [N_PROT-1:0][DATA_W-1:0] prot_q
);
  // R4
  key_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(KEY_OFS) && wdata[7:0] == ARM_KEY) |=> armed);

  // R6
  bad_key_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(KEY_OFS) && wdata[7:0] != ARM_KEY) |=> !armed);

  // R7
  other_write_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != ADDR_W'(KEY_OFS)) |=> !armed);

  // R3
  guard0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && armed && addr == ADDR_W'(prot_ofs(0))) |=> $stable(prot_q[0]));

  // R3
  guard2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && armed && addr == ADDR_W'(prot_ofs(2))) |=> $stable(prot_q[2]));

  // R9
  cfg_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(CFG_OFS)) |=> (rd_data[DATA_W-1:DATA_W-4] == REV_CODE));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind cfg_lock_bank cfg_lock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV_CODE(REV_CODE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_data(rd_data), .armed(armed), .prot_q(prot_q)
);

// File: tb/test_cfg_lock_bank.sv
module test_cfg_lock_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_lock_bank i_cfg_lock_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 plain0", v, 0);
    rd(8'h20, v); chk("R1 guard20", v, 0);
    rd(8'h80, v); chk("R1 guard80", v, 0);
    rd(8'hC0, v); chk("R1 key", v, 0);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    wr(8'h00, 32'h1234_5678);
    wr(8'h04, 32'hCAFE_F00D);
    rd(8'h00, v); chk("R2 plain0", v, 32'h1234_5678);
    rd(8'h04, v); chk("R2 plain4", v, 32'hCAFE_F00D);
  endtask

  task automatic t_locked_drop;
    logic [31:0] v;
    wr(8'h20, 32'h0000_1111);
    rd(8'h20, v); chk("R3 guard20", v, 0);
    wr(8'h24, 32'h0000_2222);
    rd(8'h24, v); chk("R3 guard24", v, 0);
  endtask

  task automatic t_unlock;
    logic [31:0] v;
    wr(8'hC0, 32'h0000_00AA);
    rd(8'hC0, v); chk("R8 armed", v, 32'h1);
    wr(8'h24, 32'h0000_BEEF);
    rd(8'h24, v); chk("R4 guard24", v, 32'h0000_BEEF);
    rd(8'hC0, v); chk("R8 disarmed", v, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(8'hC0, 32'hFFFF_FFAA);
    wr(8'h80, 32'h5);
    wr(8'h80, 32'h9);
    rd(8'h80, v); chk("R5 second dropped", v, 32'h5);
    wr(8'hC0, 32'hAA);
    wr(8'h80, 32'h5);
    rd(8'hC0, v); chk("R5 same value consumes", v, 0);
    wr(8'h80, 32'h7);
    rd(8'h80, v); chk("R5 after consume", v, 32'h5);
  endtask

  task automatic t_bad_key;
    logic [31:0] v;
    wr(8'hC0, 32'hAA);
    wr(8'hC0, 32'h55);
    rd(8'hC0, v); chk("R6 key", v, 0);
    wr(8'h20, 32'h7);
    rd(8'h20, v); chk("R6 guard20", v, 0);
  endtask

  task automatic t_intervene;
    logic [31:0] v;
    wr(8'hC0, 32'hAA);
    wr(8'h04, 32'h1);
    wr(8'h20, 32'h7);
    rd(8'h20, v); chk("R7 plain between", v, 0);
    wr(8'hC0, 32'hAA);
    wr(8'h40, 32'h3);
    rd(8'hC0, v); chk("R7 unmapped between", v, 0);
    wr(8'hC0, 32'hAA);
    wr(8'h20, 32'hA5A5_0001);
    rd(8'h20, v); chk("R4 guard20", v, 32'hA5A5_0001);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    rd(8'h9C, v); chk("R9 cfg", v, 32'h7000_0001);
    wr(8'h9C, 32'hFFFF_FFFF);
    rd(8'h9C, v); chk("R9 cfg write ignored", v, 32'h7000_0001);
    rd(8'h40, v); chk("R10 unmapped", v, 0);
    rd(8'h04, v);
    @(negedge clk); @(negedge clk);
    chk("R10 hold", rd_data, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_locked_drop();
    t_unlock();
    t_oneshot();
    t_bad_key();
    t_intervene();
    t_cfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule